// File: doc/BRIEF.md
# E1 Channel Clock and Block Strobe Generator

This block produces the per-timeslot timing strobes that a serial backplane needs next to a 2.048 Mbit/s E1 stream. It runs on the bit clock. It tracks the bit and timeslot position inside the 256-bit frame, and a frame sync pulse realigns that position. It drives two registered outputs. The channel clock strobe is high for one bit period at the end of every 8-bit timeslot, which gives a 256 kHz pulse train. The channel block strobe is held high or low over each whole timeslot, as set by a 32-bit per-timeslot mask.

The mask is split over four 8-bit registers. An optional mode, enabled by one bit in a separate mode register, forces the block strobe high during the first bit of timeslot 26 whatever the mask holds for that slot. A write-only port loads the mask registers and the mode register. Typical uses are gating the clock of a serial controller that serves only some of the timeslots, and marking timeslots for drop-and-insert.

Top module: `e1_chan_strobe_gen`

## Requirements
- R1: While rst_n is low, chan_clk and chan_blk are both 0.
- R2: When frame_sync is 1 at a rising clock edge, the outputs from the following cycle describe bit 1 of timeslot 0. This holds at any point in the frame.
- R3: With no frame_sync, the position advances by one bit per clock. After bit 8 of timeslot 31 it wraps to bit 1 of timeslot 0, so a frame is 256 cycles long.
- R4: chan_clk is 1 during bit 8 of every timeslot and 0 during bits 1 to 7. This gives exactly one high cycle in every 8.
- R5: During all 8 bits of timeslot n, chan_blk equals mask bit n. Mask register k (write address k, 0 to 3) holds bit j at timeslot 8k+j.
- R6: When mode register bit 0 (write address 4) is 1, chan_blk is 1 during bit 1 of timeslot 26 even if mask bit 26 is 0. During bits 2 to 8 of timeslot 26, chan_blk follows mask bit 26.
- R7: When mode register bit 0 is 0, chan_blk during bit 1 of timeslot 26 follows mask bit 26.
- R8: Writes to addresses 5 to 7 have no effect. Bits 7 to 1 of a mode register write have no effect.
- R9: A write sampled at a rising edge does not change the outputs updated at that same edge. It takes effect in the outputs updated at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one cycle per E1 bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | One-cycle pulse; the next cycle is bit 1 of timeslot 0 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 to 3 mask, 4 mode |
| wr_data | input | 8 | Register write data |
| chan_clk | output | 1 | High during the last bit of each timeslot |
| chan_blk | output | 1 | Per-timeslot block strobe |

## Verification
The first directed pattern uses an irregular mask in which mask bit 26 is clear, with the override off. It shows whether the mask-to-timeslot mapping and the register order are right, and whether the override stays off when it should. The override pattern is run once with bit 26 clear and once with bit 26 set. This separates a forced first bit from mask-following and confirms that the other seven bits of timeslot 26 are not forced. A long run with no sync shows whether the position wraps at the frame end. Writes to unused addresses and to the upper mode bits check that those writes change nothing. Frame syncs at random points, together with random mask and mode writes in random cycles, exercise realignment mid-frame and the one-edge write latency against a cycle-exact model in the bench.

// File: rtl/e1cs_pkg.sv
package e1cs_pkg;
   // bit of the mode register that enables the timeslot override
   localparam int OVR_EN_BIT = 0;
   // bit inside the override timeslot that is forced (0 = first bit sent)
   localparam int OVR_BIT_POS = 0;
endpackage

// File: rtl/e1cs_pos_counter.sv
module e1cs_pos_counter #(
   parameter int BITS_PER_SLOT = 8,
   parameter int NUM_SLOTS     = 32,
   localparam int BIT_W  = $clog2(BITS_PER_SLOT),
   localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_sync,
   output logic [BIT_W-1:0]  cur_bit,
   output logic [SLOT_W-1:0] cur_slot,
   output logic [BIT_W-1:0]  nxt_bit,
   output logic [SLOT_W-1:0] nxt_slot
);
   localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(BITS_PER_SLOT - 1);
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

   logic [BIT_W-1:0]  bit_q;
   logic [SLOT_W-1:0] slot_q;

   always_comb begin
      nxt_bit  = bit_q;
      nxt_slot = slot_q;
      if (frame_sync) begin
         nxt_bit  = '0;
         nxt_slot = '0;
      end else if (bit_q == LAST_BIT) begin
         nxt_bit  = '0;
         nxt_slot = (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
      end else begin
         nxt_bit  = bit_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_q  <= '0;
         slot_q <= '0;
      end else begin
         bit_q  <= nxt_bit;
         slot_q <= nxt_slot;
      end
   end

   assign cur_bit  = bit_q;
   assign cur_slot = slot_q;
endmodule

// File: rtl/e1cs_cfg_regs.sv
module e1cs_cfg_regs
   import e1cs_pkg::*;
#(
   parameter int REG_W    = 8,
   parameter int NUM_REGS = 4,
   parameter int ADDR_W   = 3,
   localparam int MASK_W  = REG_W * NUM_REGS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   output logic [MASK_W-1:0] mask_flat,
   output logic              ovr_en
);
   localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(NUM_REGS);

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_mask
      logic [REG_W-1:0] reg_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            reg_q <= '0;
         else if (wr_en && (wr_addr == ADDR_W'(g)))
            reg_q <= wr_data;
      end
      assign mask_flat[g*REG_W +: REG_W] = reg_q;
   end

   logic ovr_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ovr_q <= 1'b0;
      else if (wr_en && (wr_addr == MODE_ADDR))
         ovr_q <= wr_data[OVR_EN_BIT];
   end
   assign ovr_en = ovr_q;
endmodule

// File: rtl/e1cs_strobe.sv
module e1cs_strobe
   import e1cs_pkg::*;
#(
   parameter int BITS_PER_SLOT = 8,
   parameter int NUM_SLOTS     = 32,
   parameter int OVR_SLOT      = 26,
   parameter bit OVR_ENABLE    = 1'b1,
   localparam int BIT_W  = $clog2(BITS_PER_SLOT),
   localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [BIT_W-1:0]     nxt_bit,
   input  logic [SLOT_W-1:0]    nxt_slot,
   input  logic [NUM_SLOTS-1:0] mask,
   input  logic                 ovr_en,
   output logic                 chan_clk,
   output logic                 chan_blk
);
   localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(BITS_PER_SLOT - 1);
   localparam logic [BIT_W-1:0]  OVR_BIT   = BIT_W'(OVR_BIT_POS);
   localparam logic [SLOT_W-1:0] OVR_SLOT_L = SLOT_W'(OVR_SLOT);

   logic blk_d;
   logic mask_bit;

   assign mask_bit = mask[nxt_slot];

   if (OVR_ENABLE) begin : g_ovr
      logic at_ovr;
      assign at_ovr = (nxt_slot == OVR_SLOT_L) && (nxt_bit == OVR_BIT);
      assign blk_d  = mask_bit | (ovr_en & at_ovr);
   end else begin : g_no_ovr
      logic unused_ovr;
      assign unused_ovr = ovr_en;
      assign blk_d      = mask_bit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chan_clk <= 1'b0;
         chan_blk <= 1'b0;
      end else begin
         chan_clk <= (nxt_bit == LAST_BIT);
         chan_blk <= blk_d;
      end
   end
endmodule

// File: rtl/e1_chan_strobe_gen.sv
module e1_chan_strobe_gen #(
   parameter int BITS_PER_SLOT = 8,
   parameter int NUM_SLOTS     = 32,
   parameter int REG_W         = 8,
   parameter int ADDR_W        = 3,
   parameter int OVR_SLOT      = 26,
   parameter bit OVR_ENABLE    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_sync,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   output logic              chan_clk,
   output logic              chan_blk
);
   localparam int NUM_REGS = NUM_SLOTS / REG_W;
   localparam int BIT_W    = $clog2(BITS_PER_SLOT);
   localparam int SLOT_W   = $clog2(NUM_SLOTS);

   if (BITS_PER_SLOT < 2 || (1 << BIT_W) != BITS_PER_SLOT) begin : g_chk_bits
      $error("BITS_PER_SLOT must be a power of two of at least 2");
   end
   if (NUM_SLOTS < 2 || (1 << SLOT_W) != NUM_SLOTS) begin : g_chk_slots
      $error("NUM_SLOTS must be a power of two of at least 2");
   end
   if (NUM_SLOTS % REG_W != 0) begin : g_chk_regw
      $error("NUM_SLOTS must be a multiple of REG_W");
   end
   if ((1 << ADDR_W) <= NUM_REGS) begin : g_chk_addr
      $error("ADDR_W too narrow for mask and mode registers");
   end
   if (OVR_SLOT < 0 || OVR_SLOT >= NUM_SLOTS) begin : g_chk_ovr
      $error("OVR_SLOT outside the frame");
   end

   logic [BIT_W-1:0]     pos_bit, nxt_bit;
   logic [SLOT_W-1:0]    pos_slot, nxt_slot;
   logic [NUM_SLOTS-1:0] mask_flat;
   logic                 ovr_en_q;

   e1cs_pos_counter #(
      .BITS_PER_SLOT(BITS_PER_SLOT),
      .NUM_SLOTS    (NUM_SLOTS)
   ) u_pos (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_sync(frame_sync),
      .cur_bit   (pos_bit),
      .cur_slot  (pos_slot),
      .nxt_bit   (nxt_bit),
      .nxt_slot  (nxt_slot)
   );

   e1cs_cfg_regs #(
      .REG_W   (REG_W),
      .NUM_REGS(NUM_REGS),
      .ADDR_W  (ADDR_W)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .mask_flat(mask_flat),
      .ovr_en   (ovr_en_q)
   );

   e1cs_strobe #(
      .BITS_PER_SLOT(BITS_PER_SLOT),
      .NUM_SLOTS    (NUM_SLOTS),
      .OVR_SLOT     (OVR_SLOT),
      .OVR_ENABLE   (OVR_ENABLE)
   ) u_strb (
      .clk     (clk),
      .rst_n   (rst_n),
      .nxt_bit (nxt_bit),
      .nxt_slot(nxt_slot),
      .mask    (mask_flat),
      .ovr_en  (ovr_en_q),
      .chan_clk(chan_clk),
      .chan_blk(chan_blk)
   );
endmodule

// File: rtl/e1cs_checker.sv
module e1cs_checker #(
   parameter int BIT_W     = 3,
   parameter int SLOT_W    = 5,
   parameter int ADDR_W    = 3,
   parameter int MASK_W    = 32,
   parameter int MODE_ADDR = 4,
   parameter int OVR_SLOT  = 26
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_sync,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [BIT_W-1:0]  bit_idx,
   input logic [SLOT_W-1:0] slot_idx,
   input logic [MASK_W-1:0] mask_flat,
   input logic              ovr_en,
   input logic              chan_clk,
   input logic              chan_blk
);
   localparam logic [BIT_W-1:0]  LAST_BIT = '1;
   localparam logic [SLOT_W-1:0] OVR_S    = SLOT_W'(OVR_SLOT);
   localparam logic [ADDR_W-1:0] MODE_A   = ADDR_W'(MODE_ADDR);

   // R1: outputs held low by reset
   assert_reset_low_R1: assert property (@(posedge clk)
      !rst_n |=> (!chan_clk && !chan_blk));

   // R2: sync lands on bit 1 of timeslot 0
   assert_sync_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
      frame_sync |=> (bit_idx == '0 && slot_idx == '0 && !chan_clk));

   // R4: channel clock only on the last bit, never two in a row
   assert_clk_last_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      chan_clk |-> (bit_idx == LAST_BIT));
   assert_clk_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      chan_clk |=> !chan_clk);

   // R5: block strobe steady inside a timeslot when nothing is rewritten
   assert_blk_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_sync && !$past(wr_en) && bit_idx != LAST_BIT &&
       !(slot_idx == OVR_S && bit_idx == '0)) |=> $stable(chan_blk));

   // R6: override forces the first bit of the override slot high
   assert_ovr_force_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ovr_en) && slot_idx == OVR_S && bit_idx == '0) |-> chan_blk);

   // R8: writes above the mode address leave all state alone
   assert_ignored_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr > MODE_A) |=> ($stable(mask_flat) && $stable(ovr_en)));
endmodule

bind e1_chan_strobe_gen e1cs_checker #(
   .BIT_W    (BIT_W),
   .SLOT_W   (SLOT_W),
   .ADDR_W   (ADDR_W),
   .MASK_W   (NUM_SLOTS),
   .MODE_ADDR(NUM_REGS),
   .OVR_SLOT (OVR_SLOT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .frame_sync(frame_sync),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .bit_idx   (pos_bit),
   .slot_idx  (pos_slot),
   .mask_flat (mask_flat),
   .ovr_en    (ovr_en_q),
   .chan_clk  (chan_clk),
   .chan_blk  (chan_blk)
);

// File: tb/sim_e1_chan_strobe_gen.sv
module sim_e1_chan_strobe_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_sync = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       chan_clk, chan_blk;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // bench model state
   logic [31:0] m_mask = '0;
   logic        m_ovr = 1'b0;
   int          pos = 0;
   logic        e_clk = 1'b0, e_blk = 1'b0;
   string       e_tag = "R5";
   string       phase = "R5";

   always #5 clk = ~clk;

   e1_chan_strobe_gen u0 (
      .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .chan_clk(chan_clk), .chan_blk(chan_blk)
   );

   task automatic chk(input string tag, input string nm, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0b expected=%0b pos=%0d t=%0t",
                  tag, nm, act, exp, pos, $time);
      end
   endtask

   // expected block level for a frame position, from R5/R6/R7
   function automatic logic exp_blk_f(input int p, input logic [31:0] mk, input logic ov);
      int sl = p / 8;
      int bi = p % 8;
      if (ov && sl == 26 && bi == 0) return 1'b1;
      return mk[sl];
   endfunction

   // called at a falling edge; returns at the next falling edge
   task automatic cyc(input logic fs, input logic we, input logic [2:0] a, input logic [7:0] d);
      int np;
      chk("R4", "chan_clk", chan_clk, e_clk);
      chk(e_tag, "chan_blk", chan_blk, e_blk);
      frame_sync = fs; wr_en = we; wr_addr = a; wr_data = d;
      @(posedge clk);
      np    = fs ? 0 : (pos + 1) % 256;
      e_clk = ((np % 8) == 7);
      e_blk = exp_blk_f(np, m_mask, m_ovr);
      e_tag = phase;
      if ((np / 8) == 26 && (np % 8) == 0) e_tag = m_ovr ? "R6" : "R7";
      // R9: write lands after the outputs above are computed
      if (we) begin
         if (a < 3'd4) m_mask[a*8 +: 8] = d;
         else if (a == 3'd4) m_ovr = d[0];
      end
      pos = np;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 3'd0, 8'd0);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      cyc(1'b0, 1'b1, a, d);
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not finish actual=hung expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd24601));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk("R1", "chan_clk in reset", chan_clk, 1'b0);
      chk("R1", "chan_blk in reset", chan_blk, 1'b0);
      rst_n = 1'b1;

      // R5/R7: irregular mask, override off, mask bit 26 clear
      phase = "R5";
      wr(3'd0, 8'hA5); wr(3'd1, 8'h3C); wr(3'd2, 8'h0F); wr(3'd3, 8'hF0);
      cyc(1'b1, 1'b0, 3'd0, 8'd0);
      // R2: first cycle after sync is bit 1 of timeslot 0
      chk("R2", "chan_blk at ts0 bit1", chan_blk, 1'b1);
      chk("R2", "chan_clk at ts0 bit1", chan_clk, 1'b0);
      idle(260);

      // R3: free run across frame ends
      phase = "R3";
      idle(600);

      // R6: override on, mask bit 26 clear then set
      phase = "R6";
      wr(3'd4, 8'h01);
      cyc(1'b1, 1'b0, 3'd0, 8'd0);
      idle(256);
      wr(3'd3, 8'h04);
      idle(256);
      wr(3'd3, 8'hF0);

      // R8: ignored addresses and upper mode bits
      phase = "R8";
      for (int i = 0; i < 12; i++) begin
         wr(3'(5 + (i % 3)), 8'($urandom));
         idle(3);
      end
      wr(3'd4, 8'hFF);
      idle(300);
      wr(3'd4, 8'hFE);
      idle(300);

      // R2: sync at random points
      phase = "R2";
      for (int i = 0; i < 10; i++) begin
         idle(1 + ($urandom % 200));
         cyc(1'b1, 1'b0, 3'd0, 8'd0);
      end

      // R9: random writes and syncs mixed in
      phase = "R9";
      for (int i = 0; i < 3000; i++) begin
         int r = $urandom % 100;
         if (r < 8)
            cyc(1'b0, 1'b1, 3'($urandom % 5), 8'($urandom));
         else if (r < 9)
            cyc(1'b1, 1'b0, 3'd0, 8'd0);
         else if (r < 11)
            cyc(1'b0, 1'b1, 3'(5 + ($urandom % 3)), 8'($urandom));
         else
            cyc(1'b0, 1'b0, 3'd0, 8'd0);
      end

      done = 1'b1;
      summary();
      $finish;
   end
endmodule